// File: doc/BRIEF.md
# UART Loopback and Modem Status Unit

This unit sits between the register file of a UART and its receive queue. It decides where received entries come from and what the modem status flags show. In external mode, bytes and break events from the line receiver are forwarded to the receive queue. The four modem status flags follow the external modem pins, resynchronised to the core clock. In loopback mode, every byte written for transmission is pushed back into the receive queue, and the line receiver is cut off. The software-driven modem outputs held in the control register are reflected onto the status flags.

The mode is held by a two-state machine. `ST_EXT` is external mode and `ST_LOOP` is loopback mode. A control write with the loopback bit set takes the transition *enter loop* (`ST_EXT` to `ST_LOOP`). A control write with the bit clear takes *leave loop* (`ST_LOOP` to `ST_EXT`). Every other cycle holds the state.

Every control write with the loopback bit set copies the modem output bits onto the flags and overwrites the modem interrupt bits to match. This includes the write that enters loopback. Raising the line-break bit while in loopback injects a break entry into the receive queue.

Each receive entry is 11 bits wide. Bit 10 marks a break, bits 9:8 are zero and bits 7:0 carry the data byte. An entry appears on `rx_entry` with a one-cycle `rx_push` pulse, one clock after the event that caused it.

Top module: `uart_lpbk_modem`

## Requirements
- R1: After reset the control register reads 0x0300, the modem flags and modem interrupt bits are all zero, no entry is pushed and the unit is in external mode.
- R2: A control write with bit 7 (loopback) set updates the flags one clock later. Flag bit 8 takes control bit 13, flag bit 2 takes bit 12, flag bit 0 takes bit 11 and flag bit 1 takes bit 10. All other flag bits read zero.
- R3: The same write sets the modem interrupt bits equal to the new flags. Interrupt bit 0 equals flag 8, bit 1 equals flag 0, bit 2 equals flag 2 and bit 3 equals flag 1.
- R4: In loopback, each transmit write pushes the entry {3'b000, data} one clock later.
- R5: In external mode, transmit writes push nothing. An external byte pushes {3'b000, data}, and an external break pushes 0x400.
- R6: In loopback, external bytes, external breaks and modem pin changes have no effect. The flags hold, except when a control write mirrors new values.
- R7: In loopback, a write that takes the break bit from 0 to 1 pushes 0x400. A write that leaves the bit at 1, or takes it to 0, pushes nothing. In external mode, break writes push nothing.
- R8: A transmit or external strobe in the same cycle as a mode-changing control write is handled in the mode that held before that write.
- R9: When a loopback transmit write and a break rise fall in the same cycle, the data entry is pushed first. The break entry follows in the next cycle that has no data push.
- R10: In external mode, the flags follow the pins three clocks after a pin change. Pin 0 maps to flag 0, pin 1 to flag 1, pin 2 to flag 2 and pin 3 to flag 8. A flag change sets its interrupt bit, using the R3 mapping. An interrupt-clear strobe clears the masked interrupt bits.
- R11: `ctl_rdata` returns the last value written to the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write value |
| ctl_rdata | output | 16 | Control register contents |
| brk_wr | input | 1 | Line-control write strobe (break bit only) |
| brk_wdata | input | 1 | New line-break bit value |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | 8 | Transmit data byte |
| ext_vld | input | 1 | External receive event strobe |
| ext_brk | input | 1 | External event is a break |
| ext_data | input | 8 | External received byte |
| modem_pins | input | 4 | External modem inputs, asynchronous |
| int_clr_wr | input | 1 | Interrupt clear strobe |
| int_clr_mask | input | 4 | Interrupt bits to clear |
| rx_push | output | 1 | Receive entry valid pulse |
| rx_entry | output | 11 | Receive entry: break flag at bit 10, data at bits 7:0 |
| modem_flags | output | 9 | Modem status flag bits |
| modem_ints | output | 4 | Modem interrupt level bits |

## Verification
Two pairs of functions can coincide. The first is a mode-changing control write that lands in the same cycle as a transmit strobe. The bench provokes it both on entry to loopback and on exit from it, and judges it by whether a push follows, since the mode before the write applies. The second is a loopback transmit write that coincides with a break rise. The bench drives both in one cycle and expects the data entry in the first following cycle, 0x400 in the second, and nothing in the third. The remaining checks compute the expected flags and interrupt bits from the written control value or the pin value, sweeping all sixteen modem combinations and all 256 byte values.

// File: rtl/uart_lpbk_pkg.sv
package uart_lpbk_pkg;

    typedef enum logic {
        ST_EXT  = 1'b0,
        ST_LOOP = 1'b1
    } lpbk_state_e;

    localparam int CTL_W       = 16;
    localparam logic [CTL_W-1:0] CTL_RESET = 16'h0300;
    localparam int CB_LBE      = 7;
    localparam int CB_DTR      = 10;
    localparam int CB_RTS      = 11;
    localparam int CB_OUT1     = 12;
    localparam int CB_OUT2     = 13;

    localparam int FLAG_W      = 9;
    localparam int FB_CTS      = 0;
    localparam int FB_DSR      = 1;
    localparam int FB_DCD      = 2;
    localparam int FB_RI       = 8;

    localparam int INT_W       = 4;
    localparam int IB_RI       = 0;
    localparam int IB_CTS      = 1;
    localparam int IB_DCD      = 2;
    localparam int IB_DSR      = 3;

    function automatic logic [FLAG_W-1:0] flags_from_ctl(input logic [CTL_W-1:0] c);
        logic [FLAG_W-1:0] f;
        f         = '0;
        f[FB_RI]  = c[CB_OUT2];
        f[FB_DCD] = c[CB_OUT1];
        f[FB_CTS] = c[CB_RTS];
        f[FB_DSR] = c[CB_DTR];
        return f;
    endfunction

    function automatic logic [FLAG_W-1:0] flags_from_pins(input logic [3:0] p);
        logic [FLAG_W-1:0] f;
        f         = '0;
        f[FB_CTS] = p[0];
        f[FB_DSR] = p[1];
        f[FB_DCD] = p[2];
        f[FB_RI]  = p[3];
        return f;
    endfunction

    function automatic logic [INT_W-1:0] ints_from_flags(input logic [FLAG_W-1:0] f);
        logic [INT_W-1:0] v;
        v         = '0;
        v[IB_RI]  = f[FB_RI];
        v[IB_CTS] = f[FB_CTS];
        v[IB_DCD] = f[FB_DCD];
        v[IB_DSR] = f[FB_DSR];
        return v;
    endfunction

endpackage

// File: rtl/uart_lpbk_sync.sv
module uart_lpbk_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/uart_lpbk_modem_st.sv
module uart_lpbk_modem_st
    import uart_lpbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  lpbk_state_e       state,
    input  logic              mirror_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic [3:0]        pins_s,
    input  logic              clr_wr,
    input  logic [INT_W-1:0]  clr_mask,
    output logic [FLAG_W-1:0] flags,
    output logic [INT_W-1:0]  ints
);
    logic [FLAG_W-1:0] pin_flags;
    logic [FLAG_W-1:0] mir_flags;
    logic [INT_W-1:0]  chg_int;
    logic [INT_W-1:0]  clr_eff;

    always_comb begin
        pin_flags = flags_from_pins(pins_s);
        mir_flags = flags_from_ctl(ctl_wdata);
        chg_int   = (state == ST_EXT) ? ints_from_flags(pin_flags ^ flags) : '0;
        clr_eff   = clr_wr ? clr_mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            ints  <= '0;
        end else if (mirror_wr) begin
            flags <= mir_flags;
            ints  <= ints_from_flags(mir_flags);
        end else begin
            if (state == ST_EXT) begin
                flags <= pin_flags;
            end
            ints <= (ints & ~clr_eff) | chg_int;
        end
    end

    // R2: flags take the modem output bits of the mirrored write
    p_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mirror_wr |=> (flags[8] == $past(ctl_wdata[13])) && (flags[2] == $past(ctl_wdata[12]))
                   && (flags[0] == $past(ctl_wdata[11])) && (flags[1] == $past(ctl_wdata[10]))
                   && (flags[7:3] == 5'd0));

    // R3: interrupt bits equal the freshly mirrored flags
    p_int_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mirror_wr |=> (ints[0] == flags[8]) && (ints[1] == flags[0])
                   && (ints[2] == flags[2]) && (ints[3] == flags[1]));

    // R6: in loopback the flags move only on a mirroring write
    p_loop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOP && !mirror_wr) |=> $stable(flags));
endmodule

// File: rtl/uart_lpbk_rx_arb.sv
module uart_lpbk_rx_arb
    import uart_lpbk_pkg::*;
#(
    parameter int DATA_W  = 8,
    localparam int ENTRY_W = DATA_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lpbk_state_e        state,
    input  logic               tx_wr,
    input  logic [DATA_W-1:0]  tx_data,
    input  logic               ext_vld,
    input  logic               ext_brk,
    input  logic [DATA_W-1:0]  ext_data,
    input  logic               brk_rise,
    output logic               rx_push,
    output logic [ENTRY_W-1:0] rx_entry
);
    localparam logic [ENTRY_W-1:0] BRK_ENTRY = ENTRY_W'(1) << (ENTRY_W - 1);

    logic               pend_q;
    logic               tx_take;
    logic               ext_take;
    logic               brk_new;
    logic [ENTRY_W-1:0] data_entry;

    always_comb begin
        tx_take  = (state == ST_LOOP) && tx_wr;
        ext_take = (state == ST_EXT) && ext_vld;
        brk_new  = (state == ST_LOOP) && brk_rise;
        if (tx_take) begin
            data_entry = {3'b000, tx_data};
        end else if (ext_brk) begin
            data_entry = BRK_ENTRY;
        end else begin
            data_entry = {3'b000, ext_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            rx_push  <= 1'b0;
            rx_entry <= '0;
        end else if (tx_take || ext_take) begin
            rx_push  <= 1'b1;
            rx_entry <= data_entry;
            pend_q   <= pend_q | brk_new;
        end else if (pend_q || brk_new) begin
            rx_push  <= 1'b1;
            rx_entry <= BRK_ENTRY;
            pend_q   <= 1'b0;
        end else begin
            rx_push  <= 1'b0;
        end
    end

    // R4: loopback transmit byte appears as a plain data entry
    p_loop_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOP && tx_wr) |=> rx_push && (rx_entry == {3'b000, $past(tx_data)}));

    // R5: external mode pushes only for external events or a queued break
    p_ext_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXT && !ext_vld && !pend_q) |=> !rx_push);
endmodule

// File: rtl/uart_lpbk_modem.sv
module uart_lpbk_modem
    import uart_lpbk_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ENTRY_W    = DATA_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [15:0]        ctl_wdata,
    output logic [15:0]        ctl_rdata,
    input  logic               brk_wr,
    input  logic               brk_wdata,
    input  logic               tx_wr,
    input  logic [DATA_W-1:0]  tx_data,
    input  logic               ext_vld,
    input  logic               ext_brk,
    input  logic [DATA_W-1:0]  ext_data,
    input  logic [3:0]         modem_pins,
    input  logic               int_clr_wr,
    input  logic [3:0]         int_clr_mask,
    output logic               rx_push,
    output logic [ENTRY_W-1:0] rx_entry,
    output logic [8:0]         modem_flags,
    output logic [3:0]         modem_ints
);
    lpbk_state_e state_q, state_d;
    logic [CTL_W-1:0] ctl_q;
    logic             brk_q;
    logic             brk_rise;
    logic             mirror_wr;
    logic [3:0]       pins_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EXT;
            ctl_q   <= CTL_RESET;
            brk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctl_wr) ctl_q <= ctl_wdata;
            if (brk_wr) brk_q <= brk_wdata;
        end
    end

    // next state and decoded strobes
    always_comb begin
        state_d   = state_q;
        unique case (state_q)
            ST_EXT:  if (ctl_wr && ctl_wdata[CB_LBE])  state_d = ST_LOOP;
            ST_LOOP: if (ctl_wr && !ctl_wdata[CB_LBE]) state_d = ST_EXT;
            default: state_d = ST_EXT;
        endcase
        mirror_wr = ctl_wr && ctl_wdata[CB_LBE];
        brk_rise  = brk_wr && brk_wdata && !brk_q;
    end

    assign ctl_rdata = ctl_q;

    uart_lpbk_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (modem_pins),
        .q     (pins_s)
    );

    uart_lpbk_modem_st u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state_q),
        .mirror_wr (mirror_wr),
        .ctl_wdata (ctl_wdata),
        .pins_s    (pins_s),
        .clr_wr    (int_clr_wr),
        .clr_mask  (int_clr_mask),
        .flags     (modem_flags),
        .ints      (modem_ints)
    );

    uart_lpbk_rx_arb #(.DATA_W(DATA_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state_q),
        .tx_wr    (tx_wr),
        .tx_data  (tx_data),
        .ext_vld  (ext_vld),
        .ext_brk  (ext_brk),
        .ext_data (ext_data),
        .brk_rise (brk_rise),
        .rx_push  (rx_push),
        .rx_entry (rx_entry)
    );

    // R8: the mode after a control write follows its loopback bit
    p_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ((state_q == ST_LOOP) == $past(ctl_wdata[7])));

    // R11: control readback holds the written value
    p_ctl_rb_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_rdata == $past(ctl_wdata)));
endmodule

// File: tb/uart_lpbk_modem_tb_top.sv
`timescale 1ns/1ps
module uart_lpbk_modem_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        brk_wr = 1'b0;
    logic        brk_wdata = 1'b0;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        ext_vld = 1'b0;
    logic        ext_brk = 1'b0;
    logic [7:0]  ext_data = '0;
    logic [3:0]  modem_pins = '0;
    logic        int_clr_wr = 1'b0;
    logic [3:0]  int_clr_mask = '0;
    logic        rx_push;
    logic [10:0] rx_entry;
    logic [8:0]  modem_flags;
    logic [3:0]  modem_ints;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    uart_lpbk_modem dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .brk_wr(brk_wr), .brk_wdata(brk_wdata),
        .tx_wr(tx_wr), .tx_data(tx_data), .ext_vld(ext_vld), .ext_brk(ext_brk),
        .ext_data(ext_data), .modem_pins(modem_pins), .int_clr_wr(int_clr_wr),
        .int_clr_mask(int_clr_mask), .rx_push(rx_push), .rx_entry(rx_entry),
        .modem_flags(modem_flags), .modem_ints(modem_ints)
    );

    function automatic int exp_flags_ctl(input int c);
        return (((c >> 13) & 1) << 8) | (((c >> 12) & 1) << 2)
             | (((c >> 10) & 1) << 1) | ((c >> 11) & 1);
    endfunction

    function automatic int exp_flags_pin(input int p);
        return (((p >> 3) & 1) << 8) | (p & 7);
    endfunction

    function automatic int exp_ints(input int f);
        return ((f >> 8) & 1) | ((f & 1) << 1) | (((f >> 2) & 1) << 2) | (((f >> 1) & 1) << 3);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        ctl_wr = 1'b0; brk_wr = 1'b0; tx_wr = 1'b0; ext_vld = 1'b0;
        ext_brk = 1'b0; int_clr_wr = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int acc;
        int ctl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 32'h300);
        chk("R1 flags", modem_flags, 0);
        chk("R1 ints", modem_ints, 0);
        chk("R1 push", rx_push, 0);

        // R10 pin sweep in external mode
        acc = 0;
        for (int p = 1; p < 16; p++) begin
            modem_pins = 4'(p);
            repeat (4) step();
            acc |= exp_ints(exp_flags_pin(p) ^ exp_flags_pin(p - 1));
            chk("R10 flags", modem_flags, exp_flags_pin(p));
            chk("R10 ints", modem_ints, acc);
        end
        int_clr_wr = 1'b1; int_clr_mask = 4'b0101;
        step();
        chk("R10 partial clear", modem_ints, acc & 32'ha);
        int_clr_wr = 1'b1; int_clr_mask = 4'hf;
        step();
        chk("R10 full clear", modem_ints, 0);

        // R5 external mode sources
        tx_wr = 1'b1; tx_data = 8'h3c;
        step();
        chk("R5 tx ignored", rx_push, 0);
        for (int b = 0; b < 256; b += 37) begin
            ext_vld = 1'b1; ext_data = 8'(b);
            step();
            chk("R5 ext push", rx_push, 1);
            chk("R5 ext data", rx_entry, b);
        end
        ext_vld = 1'b1; ext_brk = 1'b1; ext_data = 8'h55;
        step();
        chk("R5 ext break", {rx_push, rx_entry}, 32'hc00);

        // R2 R3 R11 mirror sweep, first write also exercises R8 on entry
        for (int m = 0; m < 16; m++) begin
            ctl = 32'h0380 | (m << 10);
            ctl_wr = 1'b1; ctl_wdata = 16'(ctl);
            if (m == 0) begin tx_wr = 1'b1; tx_data = 8'h99; end
            step();
            if (m == 0) chk("R8 entry write uses old mode", rx_push, 0);
            chk("R2 flags", modem_flags, exp_flags_ctl(ctl));
            chk("R3 ints", modem_ints, exp_ints(exp_flags_ctl(ctl)));
            chk("R11 readback", ctl_rdata, ctl);
        end

        // R6 loopback ignores external side
        modem_pins = 4'h0;
        repeat (4) step();
        chk("R6 pins ignored", modem_flags, 32'h107);
        ext_vld = 1'b1; ext_data = 8'h11;
        step();
        chk("R6 ext byte ignored", rx_push, 0);
        ext_vld = 1'b1; ext_brk = 1'b1;
        step();
        chk("R6 ext break ignored", rx_push, 0);

        // R4 byte sweep in loopback
        for (int b = 0; b < 256; b++) begin
            tx_wr = 1'b1; tx_data = 8'(b);
            step();
            chk("R4 loop push", {rx_push, rx_entry}, 32'h800 | b);
        end

        // R7 break edges in loopback
        brk_wr = 1'b1; brk_wdata = 1'b1;
        step();
        chk("R7 rise pushes break", {rx_push, rx_entry}, 32'hc00);
        brk_wr = 1'b1; brk_wdata = 1'b1;
        step();
        chk("R7 held level silent", rx_push, 0);
        brk_wr = 1'b1; brk_wdata = 1'b0;
        step();
        chk("R7 fall silent", rx_push, 0);

        // R9 data and break in one cycle
        brk_wr = 1'b1; brk_wdata = 1'b1; tx_wr = 1'b1; tx_data = 8'ha5;
        step();
        chk("R9 data first", {rx_push, rx_entry}, 32'h8a5);
        step();
        chk("R9 break second", {rx_push, rx_entry}, 32'hc00);
        step();
        chk("R9 then idle", rx_push, 0);

        // R8 exit write with tx uses loopback mode
        ctl_wr = 1'b1; ctl_wdata = 16'h0300; tx_wr = 1'b1; tx_data = 8'h42;
        step();
        chk("R8 exit write uses old mode", {rx_push, rx_entry}, 32'h842);
        tx_wr = 1'b1; tx_data = 8'h43;
        step();
        chk("R8 external after exit", rx_push, 0);

        // R7 break rise in external mode
        brk_wr = 1'b1; brk_wdata = 1'b0;
        step();
        brk_wr = 1'b1; brk_wdata = 1'b1;
        step();
        chk("R7 ext mode break silent", rx_push, 0);
        step();
        chk("R7 ext mode break silent later", rx_push, 0);

        report();
    end
endmodule